// File: doc/BRIEF.md
# AES-128 Encryption Coprocessor

This block is an AES-128 block cipher engine that sits on a processor's coprocessor port. It encrypts only, in ECB mode. The processor presents two 64-bit operand words and a 10-bit opcode each cycle. One opcode stores the cipher key. A second opcode takes a plaintext block and starts encryption. A third opcode returns the last ciphertext as two 64-bit words. An opcode of zero means no operation.

The engine is iterative and does one round step per clock. The first step is the key whitening. Nine full rounds follow. The last step is the final round, which skips the column mixing. The round keys are derived one step ahead of the state. The stored cipher key is never overwritten, so repeated encryptions under the same key need only one key load. While a block is in flight the engine reports busy and ignores new key loads and encrypt requests. A read during that time still answers, but with its valid flag low.

Top module: `aes_cop`

## Requirements
- R1: After reset, busy, done and resValid are low and both result words read zero.
- R2: Opcode 10'h001 captures a 128-bit key: dataHi gives key bits 127:64 (first key byte in dataHi[63:56]) and dataLo gives bits 63:0.
- R3: Opcode 10'h002 captures a plaintext block with the same upper/lower split and starts encryption. busy is high from the following cycle, and done rises and busy falls exactly 11 clock edges after the edge that accepted the opcode.
- R4: The ciphertext equals the standard AES-128 result for the loaded key and the plaintext.
- R5: Opcode 10'h003 given while done is high makes resHi show ciphertext bits 127:64 and resLo bits 63:0, with resValid high, in the cycle after the accepting edge. resHi and resLo keep their value until the next read.
- R6: A read opcode given while busy returns the previous ciphertext, with resValid low.
- R7: Encrypt and key-load opcodes given while busy are ignored: the running block completes with its original data and key.
- R8: The stored key survives encryption, so a second encrypt without a reload uses the same key.
- R9: Any opcode other than 10'h001, 10'h002 and 10'h003, including 10'h000, changes neither the key, the result, done nor busy.
- R10: done and the ciphertext are held until the next accepted encrypt opcode, and that opcode clears done in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opcode | input | 10 | Coprocessor opcode, 0 = no operation |
| dataHi | input | 64 | Upper operand double word |
| dataLo | input | 64 | Lower operand double word |
| resHi | output | 64 | Upper ciphertext double word from the last read |
| resLo | output | 64 | Lower ciphertext double word from the last read |
| resValid | output | 1 | High for one cycle after a read that returned a finished result |
| busy | output | 1 | Block encryption in progress |
| done | output | 1 | A finished ciphertext is held |

## Verification
The bench checks the exact edge on which done rises. A round counter that is off by one would show done one cycle early or late. It checks three standard key and plaintext pairs, where a wrong S-box, row shift, column mix or round constant gives the wrong ciphertext. It reads while a block is in flight and expects the old ciphertext with valid low, so a design that exposed the working state or raised valid would be caught. It also issues a key load and a new encrypt mid-block and checks that the original result still appears. Finally it sends unknown opcodes and re-encrypts without a reload, which exposes a design that decodes opcodes loosely or overwrites the stored key with round keys.

// File: rtl/aes_cop_pkg.sv
package aes_cop_pkg;

  localparam int OP_W       = 10;
  localparam int HALF_W     = 64;
  localparam int BLK_W      = 2 * HALF_W;
  localparam int NUM_ROUNDS = 10;
  localparam int RND_W      = $clog2(NUM_ROUNDS + 1);

  localparam logic [OP_W-1:0] OP_LOAD_KEY = 10'h001;
  localparam logic [OP_W-1:0] OP_ENCRYPT  = 10'h002;
  localparam logic [OP_W-1:0] OP_READ     = 10'h003;

  typedef struct packed {
    logic loadKey;
    logic startEnc;
    logic roundEn;
    logic firstRound;
    logic lastRound;
    logic readOut;
  } ctrlStrobes_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = xtime(aa);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254, followed by the affine map
  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] x2, x3, x12, x15, x240, inv, s;
    x2   = gfMul(x, x);
    x3   = gfMul(x2, x);
    x12  = gfMul(gfMul(x3, x3), gfMul(x3, x3));
    x15  = gfMul(x12, x3);
    x240 = gfMul(x15, x15);
    x240 = gfMul(x240, x240);
    x240 = gfMul(x240, x240);
    x240 = gfMul(x240, x240);
    inv  = gfMul(gfMul(x240, x12), x2);
    s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
            ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    return s;
  endfunction

  // byte k of the block, k = 0 is the most significant byte
  function automatic logic [7:0] getByte(input logic [BLK_W-1:0] s, input int k);
    return s[BLK_W-1-8*k -: 8];
  endfunction

  function automatic logic [BLK_W-1:0] subBytes(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] r;
    for (int k = 0; k < 16; k++) r[BLK_W-1-8*k -: 8] = sbox(getByte(s, k));
    return r;
  endfunction

  // byte (row, col) sits at index 4*col + row
  function automatic logic [BLK_W-1:0] shiftRows(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] r;
    for (int c = 0; c < 4; c++)
      for (int row = 0; row < 4; row++)
        r[BLK_W-1-8*(4*c+row) -: 8] = getByte(s, 4*((c+row)%4) + row);
    return r;
  endfunction

  function automatic logic [BLK_W-1:0] mixColumns(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] r;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = getByte(s, 4*c);
      a1 = getByte(s, 4*c+1);
      a2 = getByte(s, 4*c+2);
      a3 = getByte(s, 4*c+3);
      r[BLK_W-1-8*(4*c)   -: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
      r[BLK_W-1-8*(4*c+1) -: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
      r[BLK_W-1-8*(4*c+2) -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
      r[BLK_W-1-8*(4*c+3) -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end
    return r;
  endfunction

  function automatic logic [BLK_W-1:0] keyStep(input logic [BLK_W-1:0] k, input logic [7:0] rcon);
    logic [31:0] w0, w1, w2, w3, t;
    w0 = k[127:96];
    w1 = k[95:64];
    w2 = k[63:32];
    w3 = k[31:0];
    t  = {sbox(w3[23:16]) ^ rcon, sbox(w3[15:8]), sbox(w3[7:0]), sbox(w3[31:24])};
    w0 = w0 ^ t;
    w1 = w1 ^ w0;
    w2 = w2 ^ w1;
    w3 = w3 ^ w2;
    return {w0, w1, w2, w3};
  endfunction

endpackage

// File: rtl/aes_cop_ctrl.sv
module aes_cop_ctrl
  import aes_cop_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  output ctrlStrobes_t    strobes,
  output logic            busy,
  output logic            done,
  output logic            resValid
);

  logic [RND_W-1:0] rndCnt;
  logic             isKey, isEnc, isRead, atLast;

  assign isKey  = (opcode == OP_LOAD_KEY);
  assign isEnc  = (opcode == OP_ENCRYPT);
  assign isRead = (opcode == OP_READ);
  assign atLast = (rndCnt == RND_W'(NUM_ROUNDS));

  always_comb begin
    strobes.loadKey    = !busy && isKey;
    strobes.startEnc   = !busy && isEnc;
    strobes.roundEn    = busy;
    strobes.firstRound = busy && (rndCnt == '0);
    strobes.lastRound  = busy && atLast;
    strobes.readOut    = isRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      rndCnt   <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= isRead && done;
      if (busy) begin
        rndCnt <= rndCnt + 1'b1;
        if (atLast) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (isEnc) begin
        busy   <= 1'b1;
        done   <= 1'b0;
        rndCnt <= '0;
      end
    end
  end

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R3

  AST_FINISH_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && atLast) |=> (done && !busy)); // R3

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !atLast) |=> (busy && rndCnt == $past(rndCnt) + 1'b1)); // R7

  AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && busy) |=> !resValid); // R6

  AST_ENC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && isEnc) |=> (!done && busy)); // R10

endmodule

// File: rtl/aes_cop_datapath.sv
module aes_cop_datapath
  import aes_cop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [HALF_W-1:0] dataHi,
  input  logic [HALF_W-1:0] dataLo,
  output logic [HALF_W-1:0] resHi,
  output logic [HALF_W-1:0] resLo
);

  logic [BLK_W-1:0] keyReg, rkReg, stateReg, resultReg;
  logic [BLK_W-1:0] subShift, fullRound, finalRound;
  logic [7:0]       rconReg;

  assign subShift   = shiftRows(subBytes(stateReg));
  assign fullRound  = mixColumns(subShift) ^ rkReg;
  assign finalRound = subShift ^ rkReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg    <= '0;
      rkReg     <= '0;
      stateReg  <= '0;
      resultReg <= '0;
      rconReg   <= 8'h01;
      resHi     <= '0;
      resLo     <= '0;
    end else begin
      if (strobes.loadKey) keyReg <= {dataHi, dataLo};
      if (strobes.startEnc) begin
        stateReg <= {dataHi, dataLo};
        rkReg    <= keyReg;
        rconReg  <= 8'h01;
      end else if (strobes.roundEn) begin
        if (strobes.firstRound)     stateReg <= stateReg ^ rkReg;
        else if (strobes.lastRound) stateReg <= finalRound;
        else                        stateReg <= fullRound;
        if (strobes.lastRound) resultReg <= finalRound;
        rkReg   <= keyStep(rkReg, rconReg);
        rconReg <= xtime(rconReg);
      end
      if (strobes.readOut) begin
        resHi <= resultReg[BLK_W-1:HALF_W];
        resLo <= resultReg[HALF_W-1:0];
      end
    end
  end

  AST_KEY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadKey |=> $stable(keyReg)); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.lastRound |=> $stable(resultReg)); // R10

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.readOut |=> ($stable(resHi) && $stable(resLo))); // R5

  AST_EXCL_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadKey && strobes.roundEn) && !(strobes.startEnc && strobes.roundEn)); // R7

endmodule

// File: rtl/aes_cop.sv
module aes_cop
  import aes_cop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opcode,
  input  logic [HALF_W-1:0] dataHi,
  input  logic [HALF_W-1:0] dataLo,
  output logic [HALF_W-1:0] resHi,
  output logic [HALF_W-1:0] resLo,
  output logic              resValid,
  output logic              busy,
  output logic              done
);

  ctrlStrobes_t strobes;

  aes_cop_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .opcode   (opcode),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done),
    .resValid (resValid)
  );

  aes_cop_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataHi  (dataHi),
    .dataLo  (dataLo),
    .resHi   (resHi),
    .resLo   (resLo)
  );

endmodule

// File: tb/aes_cop_tb.sv
module aes_cop_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  opcode = '0;
  logic [63:0] dataHi = '0, dataLo = '0;
  logic [63:0] resHi, resLo;
  logic        resValid, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [127:0] KEY_A = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] PT_A  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] CT_A  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] KEY_B = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] PT_B  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] CT_B  = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] CT_Z  = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

  always #5 clk = ~clk;

  aes_cop dut_i (
    .clk(clk), .rstN(rstN), .opcode(opcode), .dataHi(dataHi), .dataLo(dataLo),
    .resHi(resHi), .resLo(resLo), .resValid(resValid), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [9:0] op, input logic [127:0] d);
    @(negedge clk);
    opcode = op;
    dataHi = d[127:64];
    dataLo = d[63:0];
    @(negedge clk);
    opcode = '0;
    dataHi = '0;
    dataLo = '0;
  endtask

  // encrypt and check busy/done timing: edge E accepts, done after edge E+11
  task automatic encryptTimed(input logic [127:0] pt);
    issue(10'h002, pt);
    chk("R3", "busy after start", {127'd0, busy}, 128'd1);
    chk("R10", "done cleared by start", {127'd0, done}, 128'd0);
    repeat (10) @(negedge clk);
    chk("R3", "busy at edge 10", {126'd0, busy, done}, {126'd0, 2'b10});
    @(negedge clk);
    chk("R3", "done at edge 11", {126'd0, busy, done}, {126'd0, 2'b01});
  endtask

  task automatic readCheck(input string req, input logic [127:0] exp, input logic expValid);
    issue(10'h003, '0);
    chk(req, "read data", {resHi, resLo}, exp);
    chk(req, "read valid", {127'd0, resValid}, {127'd0, expValid});
  endtask

  task automatic testReset();
    chk("R1", "reset flags", {125'd0, busy, done, resValid}, 128'd0);
    chk("R1", "reset result", {resHi, resLo}, 128'd0);
  endtask

  task automatic testVectorA();
    issue(10'h001, KEY_A); // R2
    encryptTimed(PT_A);
    readCheck("R4", CT_A, 1'b1);
    @(negedge clk);
    chk("R5", "valid is one cycle", {127'd0, resValid}, 128'd0);
    chk("R5", "data held", {resHi, resLo}, CT_A);
  endtask

  task automatic testBusyCollisions();
    issue(10'h001, KEY_B); // R2
    issue(10'h002, PT_B);
    @(negedge clk);
    issue(10'h003, '0);
    chk("R6", "old result while busy", {resHi, resLo}, CT_A);
    chk("R6", "valid low while busy", {127'd0, resValid}, 128'd0);
    issue(10'h002, PT_A);          // ignored, R7
    issue(10'h001, 128'd0);        // ignored, R7
    repeat (12) @(negedge clk);
    chk("R7", "done after collisions", {126'd0, busy, done}, {126'd0, 2'b01});
    readCheck("R7", CT_B, 1'b1);
  endtask

  task automatic testKeyReuseAndJunk();
    issue(10'h3ff, 128'd0);  // R9
    issue(10'h004, 128'd0);  // R9
    issue(10'h000, 128'd0);  // R9
    chk("R9", "flags after junk", {126'd0, busy, done}, {126'd0, 2'b01});
    readCheck("R9", CT_B, 1'b1);
    repeat (3) @(negedge clk);
    chk("R10", "done still held", {127'd0, done}, 128'd1);
    encryptTimed(PT_B);          // key kept, R8
    readCheck("R8", CT_B, 1'b1);
  endtask

  task automatic testZeroVector();
    issue(10'h001, 128'd0);
    encryptTimed(128'd0);
    readCheck("R4", CT_Z, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testVectorA();
    testBusyCollisions();
    testKeyReuseAndJunk();
    testZeroVector();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule